// File: doc/BRIEF.md
# Timer Event Status Flag Bank

This block keeps one sticky status bit per timer event source and combines them into a single interrupt request. A one-cycle pulse on an event input sets the matching bit, and the bit stays set until something clears it. Software clears a bit in two steps. It first reads the flag register and sees the bit as 1, then writes 0 to that bit position. Each bit has its own armed marker that records the read-as-1. A zero-write clears a bit only when its marker is set. Writing 1 never changes a bit.

An event can be routed to a DMA channel through a per-bit link mask. When a linked bit's event has started a transfer, the DMA controller reports which bit it serves, and whether it runs as one burst or steals single bus cycles. In burst mode the bit is cleared when the transfer-complete strobe arrives. In cycle-steal mode it is cleared on each bus-release strobe. A standby strobe clears every flag and every marker. The interrupt enable mask and the link mask keep their values through standby.

Top module: `evf_flag_bank`

## Requirements
- R1: After the asynchronous reset, the flags, the armed markers, the interrupt enable mask and the DMA link mask are all 0, and irq_o is 0.
- R2: An event pulse on bit i sets flags_o[i] at the next clock edge. The bit then stays set until software, DMA or standby clears it.
- R3: A read at address 0 returns the flag vector in the same cycle. For every bit that reads 1, the read arms that bit's marker, and it has no other effect.
- R4: A write at address 0 clears, at the next edge, each bit whose data bit is 0 and whose marker is armed. Data bits of 1 leave their flags unchanged.
- R5: A data bit of 0 written to a bit whose marker is not armed is ignored.
- R6: If the event for an armed bit fires again after the read, or in the same cycle as the clearing write, the clearing write still leaves the bit at 0. The repeat event is lost.
- R7: An event in the same cycle as an ignored zero-write on an unarmed bit leaves that bit set.
- R8: A marker is dropped whenever its bit is cleared by software, by DMA or by standby. A later zero-write therefore needs a new read.
- R9: With dma_burst_i=1, dma_done_i clears the flag selected by dma_src_i when that bit's link mask bit is 1. In this mode dma_bus_rel_i is ignored, and bits whose link bit is 0 are never cleared by DMA.
- R10: With dma_burst_i=0, each dma_bus_rel_i pulse clears the linked flag selected by dma_src_i. In this mode dma_done_i is ignored.
- R11: A stby_i pulse clears all flags and markers at the next edge. The enable mask and the link mask are kept.
- R12: irq_o is 1 exactly when some flag is set and its bit in the enable mask (address 1) is also set. The enable mask and the link mask (address 2) are written and read back whole. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stby_i | input | 1 | Standby strobe; clears all flags and markers |
| evt_i | input | N_FLAGS | Per-bit event pulses |
| cpu_sel_i | input | 1 | Register access strobe |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 2 | 0 flags, 1 enable mask, 2 DMA link mask, 3 reserved |
| cpu_wdata_i | input | N_FLAGS | Write data |
| cpu_rdata_o | output | N_FLAGS | Read data (combinational) |
| dma_src_i | input | SRC_W | Index of the flag the DMA transfer serves |
| dma_burst_i | input | 1 | 1 = burst mode, 0 = cycle-steal mode |
| dma_done_i | input | 1 | Transfer-complete strobe |
| dma_bus_rel_i | input | 1 | Bus-release strobe |
| flags_o | output | N_FLAGS | Flag vector |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the bank with the default N_FLAGS=16, so SRC_W is 4. At this width the top bit (15) and the bottom bit (0) are both exercised, together with write masks such as 16'h7FFF that clear one edge bit and keep the others. With sixteen bits, a single cycle can hold an armed clear, an unarmed ignored zero-write and a fresh event at the same time, each on a different bit. The DMA source index also reaches an unlinked bit, so the link mask's gating is observed against the flags that stay set.

// File: rtl/evf_pkg.sv
package evf_pkg;
  typedef enum logic [1:0] {
    EVF_FLAG  = 2'd0,
    EVF_IEN   = 2'd1,
    EVF_DLINK = 2'd2,
    EVF_RSVD  = 2'd3
  } evf_addr_e;
endpackage

// File: rtl/evf_flag_cell.sv
module evf_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stby_i,
  input  logic evt_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic dma_clr_i,
  output logic flag_o
);
  logic flag_q, mark_q, sw_clr;

  // clear needs an armed marker; clears beat a same-cycle event
  assign sw_clr = wr_i & ~wbit_i & mark_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      mark_q <= 1'b0;
    end else if (stby_i || sw_clr || dma_clr_i) begin
      flag_q <= 1'b0;
      mark_q <= 1'b0;
    end else begin
      if (evt_i) flag_q <= 1'b1;
      if (rd_i && flag_q) mark_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  // R4
  sw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wbit_i && mark_q) |=> !flag_q);
  // R2
  evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !stby_i && !dma_clr_i && !(wr_i && !wbit_i && mark_q)) |=> flag_q);
  // R2
  rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(evt_i));
  // R5
  unarmed_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !mark_q && !dma_clr_i && !stby_i) |=> flag_q);
  // R8
  mark_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_q |-> flag_q);
  // R9
  dma_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_clr_i |=> !flag_q);
endmodule

// File: rtl/evf_dma_clr.sv
module evf_dma_clr #(
  parameter int N_FLAGS = 16,
  parameter int SRC_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SRC_W-1:0]   src_i,
  input  logic               burst_i,
  input  logic               done_i,
  input  logic               bus_rel_i,
  input  logic [N_FLAGS-1:0] link_i,
  output logic [N_FLAGS-1:0] clr_o
);
  logic fire;

  // burst: clear on completion; cycle-steal: clear on every bus release
  assign fire = burst_i ? done_i : bus_rel_i;

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_dec
    assign clr_o[i] = fire & link_i[i] & (src_i == SRC_W'(i));
  end

  // R9
  dma_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));
  // R10
  dma_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_o != '0) |-> (burst_i ? done_i : bus_rel_i));
endmodule

// File: rtl/evf_cpu_port.sv
module evf_cpu_port
  import evf_pkg::*;
#(
  parameter int N_FLAGS = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [N_FLAGS-1:0] wdata_i,
  input  logic [N_FLAGS-1:0] flags_i,
  output logic [N_FLAGS-1:0] rdata_o,
  output logic               rd_flag_o,
  output logic               wr_flag_o,
  output logic [N_FLAGS-1:0] ien_o,
  output logic [N_FLAGS-1:0] link_o
);
  evf_addr_e addr;
  logic [N_FLAGS-1:0] ien_q, link_q;

  assign addr      = evf_addr_e'(addr_i);
  assign rd_flag_o = sel_i & ~we_i & (addr == EVF_FLAG);
  assign wr_flag_o = sel_i &  we_i & (addr == EVF_FLAG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= '0;
      link_q <= '0;
    end else if (sel_i && we_i) begin
      if (addr == EVF_IEN)   ien_q  <= wdata_i;
      if (addr == EVF_DLINK) link_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && !we_i) begin
      unique case (addr)
        EVF_FLAG:  rdata_o = flags_i;
        EVF_IEN:   rdata_o = ien_q;
        EVF_DLINK: rdata_o = link_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign ien_o  = ien_q;
  assign link_o = link_q;

  // R12
  ien_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr == EVF_IEN) |=> (ien_q == $past(wdata_i)));
endmodule

// File: rtl/evf_flag_bank.sv
module evf_flag_bank #(
  parameter  int N_FLAGS = 16,
  localparam int SRC_W   = $clog2(N_FLAGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stby_i,
  input  logic [N_FLAGS-1:0] evt_i,
  input  logic               cpu_sel_i,
  input  logic               cpu_we_i,
  input  logic [1:0]         cpu_addr_i,
  input  logic [N_FLAGS-1:0] cpu_wdata_i,
  output logic [N_FLAGS-1:0] cpu_rdata_o,
  input  logic [SRC_W-1:0]   dma_src_i,
  input  logic               dma_burst_i,
  input  logic               dma_done_i,
  input  logic               dma_bus_rel_i,
  output logic [N_FLAGS-1:0] flags_o,
  output logic               irq_o
);
  logic               rd_flag, wr_flag;
  logic [N_FLAGS-1:0] ien, link, dma_clr, flags;

  evf_cpu_port #(.N_FLAGS(N_FLAGS)) u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (cpu_sel_i),
    .we_i      (cpu_we_i),
    .addr_i    (cpu_addr_i),
    .wdata_i   (cpu_wdata_i),
    .flags_i   (flags),
    .rdata_o   (cpu_rdata_o),
    .rd_flag_o (rd_flag),
    .wr_flag_o (wr_flag),
    .ien_o     (ien),
    .link_o    (link)
  );

  evf_dma_clr #(.N_FLAGS(N_FLAGS), .SRC_W(SRC_W)) u_dma (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (dma_src_i),
    .burst_i   (dma_burst_i),
    .done_i    (dma_done_i),
    .bus_rel_i (dma_bus_rel_i),
    .link_i    (link),
    .clr_o     (dma_clr)
  );

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_cell
    evf_flag_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .stby_i    (stby_i),
      .evt_i     (evt_i[i]),
      .rd_i      (rd_flag),
      .wr_i      (wr_flag),
      .wbit_i    (cpu_wdata_i[i]),
      .dma_clr_i (dma_clr[i]),
      .flag_o    (flags[i])
    );
  end

  assign flags_o = flags;
  assign irq_o   = |(flags & ien);

  // R11
  stby_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_i |=> (flags_o == '0));
  // R11
  stby_keep_ien_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_i && !cpu_sel_i) |=> $stable(ien));
endmodule

// File: tb/evf_flag_bank_test.sv
module evf_flag_bank_test;
  localparam int N = 16;
  localparam int SW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stby = 1'b0;
  logic [N-1:0]  evt = '0;
  logic          sel = 1'b0, we = 1'b0;
  logic [1:0]    addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic [SW-1:0] src = '0;
  logic          burst = 1'b0, done = 1'b0, brel = 1'b0;
  logic [N-1:0]  flags;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  evf_flag_bank #(.N_FLAGS(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .stby_i(stby), .evt_i(evt),
    .cpu_sel_i(sel), .cpu_we_i(we), .cpu_addr_i(addr), .cpu_wdata_i(wdata),
    .cpu_rdata_o(rdata), .dma_src_i(src), .dma_burst_i(burst),
    .dma_done_i(done), .dma_bus_rel_i(brel), .flags_o(flags), .irq_o(irq)
  );

  // {tag[4], evt[16], op[2] (0 idle,1 read,2 write), wdata[16], exp_flags[16]}
  localparam int NV = 14;
  localparam logic [53:0] VEC [NV] = '{
    {4'd2, 16'h0005, 2'd0, 16'h0000, 16'h0005}, // R2 set
    {4'd5, 16'h0000, 2'd2, 16'h0000, 16'h0005}, // R5 unarmed zero-write
    {4'd3, 16'h0000, 2'd1, 16'h0000, 16'h0005}, // R3 read arms 0,2
    {4'd6, 16'h0001, 2'd0, 16'h0000, 16'h0005}, // R6 repeat after read
    {4'd4, 16'h0000, 2'd2, 16'hFFFE, 16'h0004}, // R4 clear bit0 only
    {4'd7, 16'h0010, 2'd2, 16'h0000, 16'h0010}, // R7 bit4 new, bit2 cleared
    {4'd2, 16'h0004, 2'd0, 16'h0000, 16'h0014}, // R2
    {4'd8, 16'h0000, 2'd2, 16'h0000, 16'h0014}, // R8 marker dropped
    {4'd3, 16'h0000, 2'd1, 16'h0000, 16'h0014}, // R3
    {4'd6, 16'h0004, 2'd2, 16'hFFEB, 16'h0000}, // R6 same-cycle event lost
    {4'd7, 16'h8000, 2'd2, 16'h7FFF, 16'h8000}, // R7 top bit
    {4'd3, 16'h0000, 2'd1, 16'h0000, 16'h8000}, // R3
    {4'd4, 16'h0000, 2'd2, 16'hFFFF, 16'h8000}, // R4 write 1 no effect
    {4'd4, 16'h0000, 2'd2, 16'h7FFF, 16'h0000}  // R4 armed clear
  };

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [N-1:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    step();
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic cpu_rd(input string req, input logic [1:0] a, input logic [N-1:0] exp);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 chk(req, rdata, exp);
    step();
    sel = 1'b0;
  endtask

  task automatic pulse_evt(input logic [N-1:0] m);
    evt = m;
    step();
    evt = '0;
  endtask

  initial begin
    logic [N-1:0] prev;
    #20;
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", flags, '0);
    chk("R1", {15'd0, irq}, '0);
    cpu_rd("R1", 2'd1, '0);
    cpu_rd("R1", 2'd2, '0);
    cpu_rd("R12", 2'd3, '0);

    prev = '0;
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[v][53:50]);
      evt = VEC[v][49:34];
      addr = 2'd0;
      wdata = VEC[v][31:16];
      sel = (VEC[v][33:32] != 2'd0);
      we = (VEC[v][33:32] == 2'd2);
      #1;
      if (VEC[v][33:32] == 2'd1) chk("R3 rdata", rdata, prev);
      step();
      evt = '0; sel = 1'b0; we = 1'b0;
      chk(tag, flags, VEC[v][15:0]);
      prev = VEC[v][15:0];
    end

    // R12 enable mask and irq
    cpu_wr(2'd1, 16'h8001);
    cpu_rd("R12", 2'd1, 16'h8001);
    pulse_evt(16'h0002);
    chk("R12 irq masked", {15'd0, irq}, 16'd0);
    pulse_evt(16'h0001);
    chk("R12 irq", {15'd0, irq}, 16'd1);
    cpu_wr(2'd2, 16'h0003);
    cpu_rd("R12", 2'd2, 16'h0003);

    // R9 burst mode
    burst = 1'b1; src = SW'(0);
    brel = 1'b1; step(); brel = 1'b0;
    chk("R9 bus release ignored", flags, 16'h0003);
    done = 1'b1; step(); done = 1'b0;
    chk("R9 done clears", flags, 16'h0002);
    chk("R12 irq drop", {15'd0, irq}, 16'd0);
    pulse_evt(16'h0004);
    src = SW'(2);
    done = 1'b1; step(); done = 1'b0;
    chk("R9 unlinked kept", flags, 16'h0006);

    // R10 cycle-steal mode
    burst = 1'b0; src = SW'(1);
    done = 1'b1; step(); done = 1'b0;
    chk("R10 done ignored", flags, 16'h0006);
    brel = 1'b1; step(); brel = 1'b0;
    chk("R10 release clears", flags, 16'h0004);
    pulse_evt(16'h0002);
    brel = 1'b1; step(); brel = 1'b0;
    chk("R10 second release", flags, 16'h0004);

    // R11 standby
    cpu_rd("R11", 2'd0, 16'h0004);
    stby = 1'b1; step(); stby = 1'b0;
    chk("R11 flags", flags, '0);
    cpu_rd("R11 ien kept", 2'd1, 16'h8001);
    cpu_rd("R11 link kept", 2'd2, 16'h0003);
    pulse_evt(16'h0004);
    cpu_wr(2'd0, 16'h0000);
    chk("R8 marker dropped by standby", flags, 16'h0004);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R1 async", flags, '0);
    @(negedge clk); rst_n = 1'b1;
    cpu_rd("R1", 2'd1, '0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule